// File: doc/BRIEF.md
# Indexed Palette DAC Register Interface

This block is a color lookup table of 256 entries. Each entry holds an 8-bit red, an 8-bit green and an 8-bit blue value. Software loads the table through a pair of write-only 32-bit registers. The index register selects an entry. Each write to the data register supplies one color component, taken from the top byte of the write word. A small step counter tracks whether the next component is red, green or blue. When blue is written, the index moves on to the next entry, so software can stream a whole palette with one index write followed by a run of data writes.

A pixel pipeline reads colors through a valid/ready lookup stream. It presents an 8-bit index on the request side and receives the packed 24-bit color on the response side one cycle after the request is accepted. The response side has a single output register. A request is accepted only when that register is empty or is being drained in the same cycle, so back-pressure on the response side stalls the request side with no loss and no duplication. Bus reads of the register window always return zero.

Top module: `palette_dac`

## Requirements
- R1: After reset every entry reads as color 0x000000, except entry 255, which reads as 0xFFFFFF. The index and the component step are both zero, so the first data write goes to red of entry 0.
- R2: A full-word write to word address 0 loads the index from write data bits 31:24. It also returns the component step to red, even when a color is only partly written.
- R3: Full-word writes to word address 1 store write data bits 31:24 into the current entry: the first into red, the second into green, the third into blue. The packed color has red in bits 23:16, green in bits 15:8 and blue in bits 7:0.
- R4: The write that stores blue also advances the index by one, modulo 256 (entry 255 is followed by entry 0), and returns the step to red.
- R5: A write to any word address other than 0 and 1 changes neither the index, nor the step, nor any entry.
- R6: A write whose byte enables are not all four set (bus_be not equal to 4'b1111) changes neither the index, nor the step, nor any entry.
- R7: bus_rdata is zero at all times.
- R8: A lookup is accepted on a clock edge at which lk_valid and lk_ready are both high. After that edge px_valid is high and px_color holds the color of the entry named by lk_index. A color write is seen by any lookup accepted on a later edge.
- R9: lk_ready is high whenever px_valid is low or px_ready is high. While px_valid is high and px_ready is low, px_valid stays high and px_color holds its value.
- R10: A lookup accepted on the same edge as a component write to that entry returns the color as it was before that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Write strobe; the write takes effect on the rising edge where it is high |
| bus_be | input | 4 | Byte enables; only 4'b1111 is acted on |
| bus_addr | input | 4 | Word address inside the register window |
| bus_wdata | input | 32 | Write data; bits 31:24 carry the index or component |
| bus_rdata | output | 32 | Read data, always zero |
| lk_valid | input | 1 | Lookup request valid |
| lk_ready | output | 1 | Lookup request can be accepted |
| lk_index | input | 8 | Palette entry to look up |
| px_valid | output | 1 | Color response valid |
| px_ready | input | 1 | Downstream takes the color response |
| px_color | output | 24 | Packed color {red, green, blue} |

## Verification
The bench builds the block with its default parameters: 256 entries, 8-bit components, a 32-bit bus and a 4-bit word address. At this size the index wrap from 255 to 0 is reached by a short streamed load started at entry 250, and the white entry set at reset lies at the top of the same range. Unused word addresses 2 to 15 are available to test the ignored writes. Because the output stage holds a single entry, lookups can be issued on consecutive cycles while px_ready toggles. This exercises every stall and drain pattern, and it places a lookup on the same edge as a component write.

// File: rtl/palette_dac_pkg.sv
package palette_dac_pkg;

  typedef enum logic [1:0] {
    STEP_RED   = 2'd0,
    STEP_GREEN = 2'd1,
    STEP_BLUE  = 2'd2
  } comp_step_e;

  localparam int unsigned NUM_COMPS = 3;

endpackage

// File: rtl/dac_bus_decode.sv
module dac_bus_decode
  import palette_dac_pkg::*;
#(
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned BUS_W     = 32,
  parameter int unsigned IDX_W     = 8,
  parameter int unsigned COMP_W    = 8,
  parameter int unsigned IDX_ADDR  = 0,
  parameter int unsigned DATA_ADDR = 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic [BUS_W/8-1:0]   be,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [BUS_W-1:0]     wdata,
  output logic [IDX_W-1:0]     idx_q,
  output comp_step_e           step_q,
  output logic [NUM_COMPS-1:0] comp_we,
  output logic [COMP_W-1:0]    comp_val
);

  localparam int unsigned BE_W = BUS_W / 8;

  logic full_word;
  logic hit_idx;
  logic hit_dat;

  assign full_word = (be == {BE_W{1'b1}});
  assign hit_idx   = we && full_word && (addr == ADDR_W'(IDX_ADDR));
  assign hit_dat   = we && full_word && (addr == ADDR_W'(DATA_ADDR));
  assign comp_val  = wdata[BUS_W-1 -: COMP_W];

  always_comb begin
    comp_we = '0;
    if (hit_dat) begin
      unique case (step_q)
        STEP_RED:   comp_we[0] = 1'b1;
        STEP_GREEN: comp_we[1] = 1'b1;
        STEP_BLUE:  comp_we[2] = 1'b1;
        default:    comp_we    = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q  <= '0;
      step_q <= STEP_RED;
    end else if (hit_idx) begin
      idx_q  <= wdata[BUS_W-1 -: IDX_W];
      step_q <= STEP_RED;
    end else if (hit_dat) begin
      unique case (step_q)
        STEP_RED:   step_q <= STEP_GREEN;
        STEP_GREEN: step_q <= STEP_BLUE;
        default: begin
          step_q <= STEP_RED;
          idx_q  <= idx_q + 1'b1;
        end
      endcase
    end
  end

endmodule

// File: rtl/dac_palette_mem.sv
module dac_palette_mem
  import palette_dac_pkg::*;
#(
  parameter int unsigned ENTRIES = 256,
  parameter int unsigned IDX_W   = 8,
  parameter int unsigned COMP_W  = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [IDX_W-1:0]            wr_idx,
  input  logic [NUM_COMPS-1:0]        comp_we,
  input  logic [COMP_W-1:0]           comp_val,
  input  logic [IDX_W-1:0]            rd_idx,
  output logic [NUM_COMPS*COMP_W-1:0] rd_color
);

  localparam int unsigned LAST = ENTRIES - 1;

  logic [COMP_W-1:0] plane_rd [NUM_COMPS];

  for (genvar c = 0; c < NUM_COMPS; c++) begin : g_plane
    logic [COMP_W-1:0] cells [ENTRIES];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        for (int i = 0; i < ENTRIES; i++) begin
          cells[i] <= (i == LAST) ? {COMP_W{1'b1}} : '0;
        end
      end else if (comp_we[c]) begin
        cells[wr_idx] <= comp_val;
      end
    end

    assign plane_rd[c] = cells[rd_idx];
    // component 0 (red) sits in the top field of the packed color
    assign rd_color[(NUM_COMPS-1-c)*COMP_W +: COMP_W] = plane_rd[c];
  end

endmodule

// File: rtl/dac_lookup_stage.sv
module dac_lookup_stage #(
  parameter int unsigned IDX_W = 8,
  parameter int unsigned COL_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [IDX_W-1:0] in_index,
  output logic [IDX_W-1:0] mem_idx,
  input  logic [COL_W-1:0] mem_color,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [COL_W-1:0] out_color
);

  logic accept;

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;
  assign mem_idx  = in_index;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_color <= '0;
    end else begin
      if (accept) begin
        out_valid <= 1'b1;
        out_color <= mem_color;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/palette_dac.sv
module palette_dac
  import palette_dac_pkg::*;
#(
  parameter int unsigned ENTRIES   = 256,
  parameter int unsigned COMP_W    = 8,
  parameter int unsigned BUS_W     = 32,
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned IDX_ADDR  = 0,
  parameter int unsigned DATA_ADDR = 1,
  localparam int unsigned IDX_W    = $clog2(ENTRIES),
  localparam int unsigned COL_W    = NUM_COMPS * COMP_W,
  localparam int unsigned BE_W     = BUS_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [BE_W-1:0]   bus_be,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic              lk_valid,
  output logic              lk_ready,
  input  logic [IDX_W-1:0]  lk_index,
  output logic              px_valid,
  input  logic              px_ready,
  output logic [COL_W-1:0]  px_color
);

  logic [IDX_W-1:0]     cur_idx;
  comp_step_e           cur_step;
  logic [NUM_COMPS-1:0] comp_we;
  logic [COMP_W-1:0]    comp_val;
  logic [IDX_W-1:0]     rd_idx;
  logic [COL_W-1:0]     rd_color;

  assign bus_rdata = '0;

  dac_bus_decode #(
    .ADDR_W(ADDR_W), .BUS_W(BUS_W), .IDX_W(IDX_W), .COMP_W(COMP_W),
    .IDX_ADDR(IDX_ADDR), .DATA_ADDR(DATA_ADDR)
  ) u_decode (
    .clk(clk), .rst_n(rst_n), .we(bus_we), .be(bus_be), .addr(bus_addr),
    .wdata(bus_wdata), .idx_q(cur_idx), .step_q(cur_step),
    .comp_we(comp_we), .comp_val(comp_val)
  );

  dac_palette_mem #(
    .ENTRIES(ENTRIES), .IDX_W(IDX_W), .COMP_W(COMP_W)
  ) u_mem (
    .clk(clk), .rst_n(rst_n), .wr_idx(cur_idx), .comp_we(comp_we),
    .comp_val(comp_val), .rd_idx(rd_idx), .rd_color(rd_color)
  );

  dac_lookup_stage #(
    .IDX_W(IDX_W), .COL_W(COL_W)
  ) u_look (
    .clk(clk), .rst_n(rst_n), .in_valid(lk_valid), .in_ready(lk_ready),
    .in_index(lk_index), .mem_idx(rd_idx), .mem_color(rd_color),
    .out_valid(px_valid), .out_ready(px_ready), .out_color(px_color)
  );

endmodule

// File: rtl/palette_dac_chk.sv
module palette_dac_chk #(
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned BUS_W     = 32,
  parameter int unsigned IDX_W     = 8,
  parameter int unsigned COL_W     = 24,
  parameter int unsigned IDX_ADDR  = 0,
  parameter int unsigned DATA_ADDR = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_we,
  input logic [BUS_W/8-1:0] bus_be,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [BUS_W-1:0]  bus_wdata,
  input logic [BUS_W-1:0]  bus_rdata,
  input logic              lk_valid,
  input logic              lk_ready,
  input logic              px_valid,
  input logic              px_ready,
  input logic [COL_W-1:0]  px_color,
  input logic [IDX_W-1:0]  idx_q,
  input logic [1:0]        step_q
);

  logic full_w;
  assign full_w = &bus_be;

  p_rdata_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata == '0);

  p_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_ready) |=> px_valid);

  p_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!px_valid || px_ready) |-> lk_ready);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (px_valid && !px_ready) |=> (px_valid && $stable(px_color)));

  p_idx_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && full_w && bus_addr == ADDR_W'(IDX_ADDR))
      |=> (idx_q == $past(bus_wdata[BUS_W-1 -: IDX_W]) && step_q == 2'd0));

  p_step_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
    step_q != 2'd3);

  p_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && full_w && bus_addr == ADDR_W'(DATA_ADDR) && step_q == 2'd2)
      |=> (step_q == 2'd0 && idx_q == IDX_W'($past(idx_q) + 1'b1)));

  p_partial_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && !full_w) |=> ($stable(idx_q) && $stable(step_q)));

  p_other_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr != ADDR_W'(IDX_ADDR) && bus_addr != ADDR_W'(DATA_ADDR))
      |=> ($stable(idx_q) && $stable(step_q)));

endmodule

bind palette_dac palette_dac_chk #(
  .ADDR_W(ADDR_W), .BUS_W(BUS_W), .IDX_W(IDX_W), .COL_W(COL_W),
  .IDX_ADDR(IDX_ADDR), .DATA_ADDR(DATA_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_be(bus_be),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .lk_valid(lk_valid), .lk_ready(lk_ready), .px_valid(px_valid),
  .px_ready(px_ready), .px_color(px_color), .idx_q(cur_idx),
  .step_q(cur_step)
);

// File: tb/sim_palette_dac.sv
module sim_palette_dac;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [3:0]  bus_be = 4'h0;
  logic [3:0]  bus_addr = 4'h0;
  logic [31:0] bus_wdata = 32'h0;
  logic [31:0] bus_rdata;
  logic        lk_valid = 1'b0;
  logic        lk_ready;
  logic [7:0]  lk_index = 8'h0;
  logic        px_valid;
  logic        px_ready = 1'b1;
  logic [23:0] px_color;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct { logic [23:0] color; string req; } exp_t;
  exp_t exp_q[$];

  logic [23:0] mdl [256];
  logic [7:0]  idx_m;
  int          step_m;

  always #5 clk = ~clk;

  palette_dac u0 (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_be(bus_be),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_index(lk_index),
    .px_valid(px_valid), .px_ready(px_ready), .px_color(px_color)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", checks, fails);
  endtask

  // model of the register rules
  task automatic model_apply(input logic [3:0] a, input logic [3:0] be,
                             input logic [31:0] d);
    if (be == 4'hF) begin
      if (a == 4'd0) begin
        idx_m  = d[31:24];
        step_m = 0;
      end else if (a == 4'd1) begin
        case (step_m)
          0: begin mdl[idx_m][23:16] = d[31:24]; step_m = 1; end
          1: begin mdl[idx_m][15:8]  = d[31:24]; step_m = 2; end
          default: begin
            mdl[idx_m][7:0] = d[31:24];
            idx_m  = idx_m + 8'd1;
            step_m = 0;
          end
        endcase
      end
    end
  endtask

  task automatic bus_wr(input logic [3:0] a, input logic [3:0] be,
                        input logic [31:0] d);
    bus_we = 1'b1; bus_be = be; bus_addr = a; bus_wdata = d;
    @(posedge clk); #2;
    bus_we = 1'b0;
    model_apply(a, be, d);
  endtask

  task automatic look(input logic [7:0] idx, input string req);
    bit acc;
    exp_t e;
    e.color = mdl[idx];
    e.req   = req;
    exp_q.push_back(e);
    lk_valid = 1'b1; lk_index = idx;
    do begin
      @(negedge clk); acc = lk_ready;
      @(posedge clk); #2;
    end while (!acc);
    lk_valid = 1'b0;
  endtask

  task automatic wr_look(input logic [3:0] a, input logic [31:0] d,
                         input logic [7:0] idx, input string req);
    exp_t e;
    e.color = mdl[idx];
    e.req   = req;
    exp_q.push_back(e);
    bus_we = 1'b1; bus_be = 4'hF; bus_addr = a; bus_wdata = d;
    lk_valid = 1'b1; lk_index = idx;
    @(posedge clk); #2;
    bus_we = 1'b0; lk_valid = 1'b0;
    model_apply(a, 4'hF, d);
  endtask

  task automatic set_rgb(input logic [7:0] r, input logic [7:0] g,
                         input logic [7:0] b);
    bus_wr(4'd1, 4'hF, {r, 24'h5A5A5A});
    bus_wr(4'd1, 4'hF, {g, 24'hA5A5A5});
    bus_wr(4'd1, 4'hF, {b, 24'h0F0F0F});
  endtask

  task automatic drain();
    for (int k = 0; k < 200 && exp_q.size() != 0; k++) @(posedge clk);
    #2;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && px_valid && px_ready) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R8 unexpected response", {8'h0, px_color}, 32'h0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(px_color == e.color, e.req, {8'h0, px_color}, {8'h0, e.color});
      end
    end
    if (rst_n) begin
      if (bus_rdata != 32'h0) chk(1'b0, "R7 rdata", bus_rdata, 32'h0);
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) mdl[i] = (i == 255) ? 24'hFFFFFF : 24'h0;
    idx_m = 8'd0; step_m = 0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;

    // R1 reset state
    @(negedge clk);
    chk(px_valid == 1'b0, "R1 px_valid after reset", {31'h0, px_valid}, 32'h0);
    chk(lk_ready == 1'b1, "R9 lk_ready when empty", {31'h0, lk_ready}, 32'h1);
    chk(bus_rdata == 32'h0, "R7 rdata zero", bus_rdata, 32'h0);
    @(posedge clk); #2;
    look(8'd0, "R1 entry 0 black");
    look(8'd128, "R1 entry 128 black");
    look(8'd254, "R1 entry 254 black");
    look(8'd255, "R1 entry 255 white");
    // R1: step and index start at red of entry 0
    set_rgb(8'h12, 8'h34, 8'h56);
    look(8'd0, "R1 first data goes to entry 0");
    drain();

    // R2/R3 index load and component order
    bus_wr(4'd0, 4'hF, 32'h07_FFFFFF);
    set_rgb(8'hAA, 8'hBB, 8'hCC);
    look(8'd7, "R3 rgb order entry 7");
    // R4 auto increment
    set_rgb(8'h01, 8'h02, 8'h03);
    look(8'd8, "R4 increment to entry 8");
    // R2 index write resets step mid-color
    bus_wr(4'd0, 4'hF, 32'd20 << 24);
    bus_wr(4'd1, 4'hF, 32'h10_000000);
    bus_wr(4'd0, 4'hF, 32'd21 << 24);
    set_rgb(8'h21, 8'h22, 8'h23);
    look(8'd20, "R2 partial color entry 20");
    look(8'd21, "R2 step reset entry 21");
    drain();

    // R5/R6 ignored writes
    bus_wr(4'd0, 4'hF, 32'd40 << 24);
    bus_wr(4'd1, 4'hF, 32'h11_000000);
    bus_wr(4'd2, 4'hF, 32'h99_000000);
    bus_wr(4'd15, 4'hF, 32'h98_000000);
    bus_wr(4'd1, 4'h7, 32'h77_000000);
    bus_wr(4'd0, 4'hE, 32'd90 << 24);
    bus_wr(4'd1, 4'hF, 32'h22_000000);
    bus_wr(4'd1, 4'hF, 32'h33_000000);
    look(8'd40, "R5 R6 ignored writes keep step");
    set_rgb(8'h44, 8'h55, 8'h66);
    look(8'd41, "R6 partial index write ignored");
    look(8'd90, "R6 entry 90 untouched");
    drain();

    // R10 same-edge lookup sees old value, next sees new
    bus_wr(4'd0, 4'hF, 32'd60 << 24);
    bus_wr(4'd1, 4'hF, 32'hC1_000000);
    bus_wr(4'd1, 4'hF, 32'hC2_000000);
    wr_look(4'd1, 32'hC3_000000, 8'd60, "R10 same edge old color");
    look(8'd60, "R8 next cycle new color");
    drain();

    // R4 wrap 255 -> 0
    bus_wr(4'd0, 4'hF, 32'd250 << 24);
    for (int i = 0; i < 9; i++)
      set_rgb(8'(i * 16 + 1), 8'(i * 16 + 2), 8'(i * 16 + 3));
    for (int i = 250; i < 259; i++) look(8'(i), "R4 streamed wrap");
    drain();

    // R9 back-pressure
    px_ready = 1'b0;
    look(8'd252, "R9 held response");
    @(negedge clk);
    begin
      logic [23:0] held;
      held = px_color;
      chk(px_valid == 1'b1, "R9 valid while stalled", {31'h0, px_valid}, 32'h1);
      chk(lk_ready == 1'b0, "R9 ready low when full", {31'h0, lk_ready}, 32'h0);
      repeat (3) @(negedge clk);
      chk(px_color == held, "R9 color stable", {8'h0, px_color}, {8'h0, held});
      chk(px_valid == 1'b1, "R9 valid held", {31'h0, px_valid}, 32'h1);
    end
    @(posedge clk); #2;
    px_ready = 1'b1;
    drain();

    // R8 back-to-back lookups with toggling px_ready
    fork
      begin
        for (int i = 0; i < 60; i++) begin
          px_ready = (i % 3) != 0;
          @(posedge clk); #2;
        end
        px_ready = 1'b1;
      end
      begin
        for (int i = 0; i < 24; i++) look(8'(245 + i), "R8 stream lookup");
      end
    join
    drain();
    chk(exp_q.size() == 0, "R8 all responses delivered", exp_q.size(), 32'h0);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule